// File: doc/BRIEF.md
# Highest-priority pending interrupt selector

This block looks at every shared interrupt of an interrupt controller and, for each processor core, finds the one interrupt that core should be told about. An interrupt can compete when it is pending, enabled, not already active, and its security group is switched on. The caller supplies all of this per-interrupt state as flat vectors, together with a 64-bit routing value for each interrupt. The block keeps none of it.

Routing works in one of two ways. In the first, the routing value carries four 8-bit affinity fields, and the interrupt goes to the core whose fixed affinity ID matches all four. In the second, set by a mode bit, the interrupt goes to the lowest-numbered core that takes part in any-core delivery and is willing to accept that interrupt's group.

For each core the block reports a hit flag, the winning interrupt ID, its priority and its group. With no winner it reports the idle state. The path has two register stages. The first registers eligibility and target per interrupt. The second registers the result of a per-core comparison tree. A new input value reaches the outputs after two clock edges.

Top module: `hppi_select`

## Requirements
- R1: An interrupt competes only when all four hold: its `pend_i` bit is 1, its `en_i` bit is 1, its `act_i` bit is 0, and the `grp_en_i` bit of its resolved group is 1.
- R2: Group resolution uses the codes 0 = secure group 0, 1 = secure group 1 and 2 = non-secure group 1. A `grp_i` bit of 1 always gives code 2. With `grp_i` at 0, the result is code 1 when `sec_dis_i` is 0 and `grp_mod_i` is 1, and code 0 otherwise. `grp_en_i[k]` enables group code k, and `grp_o` reports the code.
- R3: Among the candidates of one core, the lowest priority value wins. When priorities are equal, the lowest interrupt ID wins.
- R4: An interrupt with priority 0xFF is never signalled. An idle core shows `hit_o`=0, priority 0xFF, ID 0 and group 0.
- R5: When bit 31 of the routing value is 0, the value {bits[39:32], bits[23:16], bits[15:8], bits[7:0]} must equal the core's `CORE_AFF` entry. With the default parameters, core c has the affinity 32'h0000_0100 + c.
- R6: When bit 31 of the routing value is 1, the target is the lowest-index core c with `core_part_i[c]`=1 and `core_take_i[3*c + group code]`=1.
- R7: An eligible interrupt whose routing matches no core is signalled to no core and does not change any core's result.
- R8: Input bit i (and slice i) describes interrupt ID 32+i. Only IDs 32 to NUM_IDS-1 take part.
- R9: A change in the inputs appears at the outputs after exactly two rising clock edges. This holds both for a new winner and for the removal of a winner by clearing or disabling it.
- R10: While `rst_n` is low, every core shows the idle state, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_dis_i | input | 1 | Security disabled; the group modifier bit is ignored |
| grp_en_i | input | 3 | Enable per group code |
| pend_i | input | NUM_IDS-32 | Pending bit per shared interrupt |
| en_i | input | NUM_IDS-32 | Enable bit per shared interrupt |
| act_i | input | NUM_IDS-32 | Active bit per shared interrupt |
| grp_i | input | NUM_IDS-32 | Group bit per shared interrupt |
| grp_mod_i | input | NUM_IDS-32 | Group modifier bit per shared interrupt |
| prio_i | input | 8*(NUM_IDS-32) | Priority per interrupt; lower value is more urgent |
| route_i | input | 64*(NUM_IDS-32) | Routing value per interrupt |
| core_part_i | input | NUM_CORES | Core takes part in any-core delivery |
| core_take_i | input | 3*NUM_CORES | Core willing to accept a group, indexed 3*core + group code |
| hit_o | output | NUM_CORES | Core has a winner |
| id_o | output | NUM_CORES*clog2(NUM_IDS) | Winning interrupt ID per core |
| prio_o | output | 8*NUM_CORES | Winning priority per core, 0xFF when idle |
| grp_o | output | 2*NUM_CORES | Winning group code per core |

## Verification
The assertions assume that the per-interrupt status and routing inputs come from registers clocked by `clk`, so that each value is stable for a whole cycle. They also assume that the `CORE_AFF` entries are distinct, so that a direct route matches at most one core. The bench changes inputs only one time unit after a rising edge. It keeps the default, distinct affinities, so every value an assertion samples was set up one full cycle earlier.

// File: rtl/hppi_pkg.sv
package hppi_pkg;
  localparam int FIRST_SHARED = 32;
  localparam int ROUTE_W = 64;
  localparam int ROUTE_MODE_BIT = 31;
  localparam logic [7:0] IDLE_PRIO = 8'hFF;

  typedef enum logic [1:0] {
    GRP_S0  = 2'd0,
    GRP_S1  = 2'd1,
    GRP_NS1 = 2'd2
  } grp_e;

  // Group code from the group bit, the modifier bit and the security switch
  function automatic grp_e resolve_grp(input logic sec_dis, input logic grp_bit,
                                       input logic mod_bit);
    if (grp_bit) return GRP_NS1;
    if (!sec_dis && mod_bit) return GRP_S1;
    return GRP_S0;
  endfunction

  // Four affinity fields packed as {aff3, aff2, aff1, aff0}
  function automatic logic [31:0] route_aff(input logic [ROUTE_W-1:0] r);
    return {r[39:32], r[23:16], r[15:8], r[7:0]};
  endfunction

  // True when candidate b must replace candidate a (a holds the lower IDs)
  function automatic logic b_wins(input logic va, input logic [7:0] pa,
                                  input logic vb, input logic [7:0] pb);
    return vb && (!va || (pb < pa));
  endfunction
endpackage

// File: rtl/hppi_elig.sv
module hppi_elig
  import hppi_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int NUM_CORES = 4,
  parameter logic [NUM_CORES*32-1:0] CORE_AFF = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sec_dis_i,
  input  logic [2:0]                   grp_en_i,
  input  logic [NUM_SPI-1:0]           pend_i,
  input  logic [NUM_SPI-1:0]           en_i,
  input  logic [NUM_SPI-1:0]           act_i,
  input  logic [NUM_SPI-1:0]           grp_i,
  input  logic [NUM_SPI-1:0]           grp_mod_i,
  input  logic [NUM_SPI*8-1:0]         prio_i,
  input  logic [NUM_SPI*ROUTE_W-1:0]   route_i,
  input  logic [NUM_CORES-1:0]         core_part_i,
  input  logic [NUM_CORES*3-1:0]       core_take_i,
  output logic [NUM_SPI-1:0]           cand_v_o,
  output logic [NUM_SPI*NUM_CORES-1:0] cand_tgt_o,
  output logic [NUM_SPI*8-1:0]         cand_prio_o,
  output logic [NUM_SPI*2-1:0]         cand_grp_o
);
  for (genvar i = 0; i < NUM_SPI; i++) begin : g_irq
    logic [ROUTE_W-1:0]   route;
    grp_e                 grp;
    logic                 elig;
    logic [NUM_CORES-1:0] tgt;
    logic                 found;
    logic                 match;
    logic                 v_q;
    logic [NUM_CORES-1:0] tgt_q;
    logic [7:0]           prio_q;
    grp_e                 grp_q;

    assign route = route_i[i*ROUTE_W +: ROUTE_W];
    always_comb grp = resolve_grp(sec_dis_i, grp_i[i], grp_mod_i[i]);

    assign elig = pend_i[i] & en_i[i] & ~act_i[i] & grp_en_i[grp] &
                  (prio_i[i*8 +: 8] != IDLE_PRIO);

    // Target: first core in index order that accepts the interrupt
    always_comb begin
      tgt   = '0;
      found = 1'b0;
      match = 1'b0;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (route[ROUTE_MODE_BIT])
          match = core_part_i[c] & core_take_i[c*3 + int'(grp)];
        else
          match = (route_aff(route) == CORE_AFF[c*32 +: 32]);
        if (match && !found) begin
          tgt[c] = 1'b1;
          found  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        tgt_q  <= '0;
        prio_q <= IDLE_PRIO;
        grp_q  <= GRP_S0;
      end else begin
        v_q    <= elig;
        tgt_q  <= tgt;
        prio_q <= prio_i[i*8 +: 8];
        grp_q  <= grp;
      end
    end

    assign cand_v_o[i]                         = v_q;
    assign cand_tgt_o[i*NUM_CORES +: NUM_CORES] = tgt_q;
    assign cand_prio_o[i*8 +: 8]               = prio_q;
    assign cand_grp_o[i*2 +: 2]                = grp_q;

    // R1
    elig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q |-> $past(pend_i[i] && en_i[i] && !act_i[i]));
    // R6
    tgt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_q));
  end
endmodule

// File: rtl/hppi_tree.sv
module hppi_tree
  import hppi_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int ID_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SPI-1:0]   leaf_v_i,
  input  logic [NUM_SPI*8-1:0] leaf_prio_i,
  input  logic [NUM_SPI*2-1:0] leaf_grp_i,
  output logic                 hit_o,
  output logic [ID_W-1:0]      id_o,
  output logic [7:0]           prio_o,
  output logic [1:0]           grp_o
);
  localparam int LEAVES = 1 << $clog2(NUM_SPI);
  localparam int NODES  = 2*LEAVES - 1;
  localparam int IDX_W  = (LEAVES > 1) ? $clog2(LEAVES) : 1;

  logic [LEAVES-1:0]   pad_v;
  logic [LEAVES*8-1:0] pad_p;
  logic [LEAVES*2-1:0] pad_g;
  assign pad_v = LEAVES'(leaf_v_i);
  assign pad_p = (LEAVES*8)'(leaf_prio_i);
  assign pad_g = (LEAVES*2)'(leaf_grp_i);

  logic             nv [NODES];
  logic [7:0]       np [NODES];
  logic [1:0]       ng [NODES];
  logic [IDX_W-1:0] ni [NODES];

  // Heap-ordered tree; the left child always holds the lower IDs
  always_comb begin
    for (int n = 0; n < LEAVES; n++) begin
      nv[LEAVES-1+n] = pad_v[n];
      np[LEAVES-1+n] = pad_p[n*8 +: 8];
      ng[LEAVES-1+n] = pad_g[n*2 +: 2];
      ni[LEAVES-1+n] = IDX_W'(n);
    end
    for (int n = LEAVES-2; n >= 0; n--) begin
      if (b_wins(nv[2*n+1], np[2*n+1], nv[2*n+2], np[2*n+2])) begin
        nv[n] = nv[2*n+2]; np[n] = np[2*n+2];
        ng[n] = ng[2*n+2]; ni[n] = ni[2*n+2];
      end else begin
        nv[n] = nv[2*n+1]; np[n] = np[2*n+1];
        ng[n] = ng[2*n+1]; ni[n] = ni[2*n+1];
      end
    end
  end

  logic            hit_q;
  logic [ID_W-1:0] id_q;
  logic [7:0]      prio_q;
  logic [1:0]      grp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      id_q   <= '0;
      prio_q <= IDLE_PRIO;
      grp_q  <= 2'd0;
    end else if (nv[0]) begin
      hit_q  <= 1'b1;
      id_q   <= ID_W'(FIRST_SHARED) + ID_W'(ni[0]);
      prio_q <= np[0];
      grp_q  <= ng[0];
    end else begin
      hit_q  <= 1'b0;
      id_q   <= '0;
      prio_q <= IDLE_PRIO;
      grp_q  <= 2'd0;
    end
  end

  assign hit_o  = hit_q;
  assign id_o   = id_q;
  assign prio_o = prio_q;
  assign grp_o  = grp_q;

  // R4
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_q |-> (prio_q == IDLE_PRIO && id_q == '0 && grp_q == 2'd0));
  // R4
  live_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> prio_q != IDLE_PRIO);
  // R8
  id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (32'(id_q) >= FIRST_SHARED && 32'(id_q) < FIRST_SHARED + NUM_SPI));
  // R9
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|leaf_v_i) |=> hit_q);
  // R9
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|leaf_v_i) |=> !hit_q);

  for (genvar j = 0; j < NUM_SPI; j++) begin : g_leaf_chk
    // R3
    best_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      leaf_v_i[j] |=> (hit_q && prio_q <= $past(leaf_prio_i[j*8 +: 8])));
  end
endmodule

// File: rtl/hppi_select.sv
module hppi_select
  import hppi_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int NUM_CORES = 4,
  parameter logic [NUM_CORES*32-1:0] CORE_AFF =
    {32'h0000_0103, 32'h0000_0102, 32'h0000_0101, 32'h0000_0100}
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   sec_dis_i,
  input  logic [2:0]                             grp_en_i,
  input  logic [NUM_IDS-33:0]                    pend_i,
  input  logic [NUM_IDS-33:0]                    en_i,
  input  logic [NUM_IDS-33:0]                    act_i,
  input  logic [NUM_IDS-33:0]                    grp_i,
  input  logic [NUM_IDS-33:0]                    grp_mod_i,
  input  logic [(NUM_IDS-32)*8-1:0]              prio_i,
  input  logic [(NUM_IDS-32)*64-1:0]             route_i,
  input  logic [NUM_CORES-1:0]                   core_part_i,
  input  logic [NUM_CORES*3-1:0]                 core_take_i,
  output logic [NUM_CORES-1:0]                   hit_o,
  output logic [NUM_CORES*$clog2(NUM_IDS)-1:0]   id_o,
  output logic [NUM_CORES*8-1:0]                 prio_o,
  output logic [NUM_CORES*2-1:0]                 grp_o
);
  localparam int NUM_SPI = NUM_IDS - FIRST_SHARED;
  localparam int ID_W    = $clog2(NUM_IDS);

  logic [NUM_SPI-1:0]           cand_v;
  logic [NUM_SPI*NUM_CORES-1:0] cand_tgt;
  logic [NUM_SPI*8-1:0]         cand_prio;
  logic [NUM_SPI*2-1:0]         cand_grp;

  hppi_elig #(
    .NUM_SPI(NUM_SPI), .NUM_CORES(NUM_CORES), .CORE_AFF(CORE_AFF)
  ) u_elig (
    .clk(clk), .rst_n(rst_n), .sec_dis_i(sec_dis_i), .grp_en_i(grp_en_i),
    .pend_i(pend_i), .en_i(en_i), .act_i(act_i), .grp_i(grp_i),
    .grp_mod_i(grp_mod_i), .prio_i(prio_i), .route_i(route_i),
    .core_part_i(core_part_i), .core_take_i(core_take_i),
    .cand_v_o(cand_v), .cand_tgt_o(cand_tgt), .cand_prio_o(cand_prio),
    .cand_grp_o(cand_grp)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_SPI-1:0] leaf_v;
    always_comb
      for (int i = 0; i < NUM_SPI; i++)
        leaf_v[i] = cand_v[i] & cand_tgt[i*NUM_CORES + c];

    hppi_tree #(.NUM_SPI(NUM_SPI), .ID_W(ID_W)) u_tree (
      .clk(clk), .rst_n(rst_n), .leaf_v_i(leaf_v), .leaf_prio_i(cand_prio),
      .leaf_grp_i(cand_grp), .hit_o(hit_o[c]), .id_o(id_o[c*ID_W +: ID_W]),
      .prio_o(prio_o[c*8 +: 8]), .grp_o(grp_o[c*2 +: 2])
    );
  end

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> hit_o == '0);
endmodule

// File: tb/sim_hppi_select.sv
module sim_hppi_select;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IDS = 64;
  localparam int NUM_CORES = 4;
  localparam int NSPI = NUM_IDS - 32;
  localparam int ID_W = $clog2(NUM_IDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_dis;
  logic [2:0] grp_en;
  logic [NSPI-1:0] pend, en, act, grp, gmod;
  logic [NSPI*8-1:0] prio;
  logic [NSPI*64-1:0] route;
  logic [NUM_CORES-1:0] part;
  logic [NUM_CORES*3-1:0] take;
  logic [NUM_CORES-1:0] hit_o;
  logic [NUM_CORES*ID_W-1:0] id_o;
  logic [NUM_CORES*8-1:0] prio_o;
  logic [NUM_CORES*2-1:0] grp_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hppi_select #(.NUM_IDS(NUM_IDS), .NUM_CORES(NUM_CORES)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_dis_i(sec_dis), .grp_en_i(grp_en),
    .pend_i(pend), .en_i(en), .act_i(act), .grp_i(grp), .grp_mod_i(gmod),
    .prio_i(prio), .route_i(route), .core_part_i(part), .core_take_i(take),
    .hit_o(hit_o), .id_o(id_o), .prio_o(prio_o), .grp_o(grp_o)
  );

  // Vectors: {idx_a, prio_a, idx_b, prio_b, core, exp_id, exp_prio}
  localparam logic [55:0] VEC [0:5] = '{
    {8'd0,  8'h40, 8'd5,  8'h20, 8'd0, 8'd37, 8'h20},
    {8'd3,  8'h10, 8'd9,  8'h10, 8'd1, 8'd35, 8'h10},
    {8'd31, 8'h10, 8'd30, 8'h10, 8'd2, 8'd62, 8'h10},
    {8'd0,  8'hFF, 8'd1,  8'hFF, 8'd3, 8'd0,  8'hFF},
    {8'd2,  8'hFE, 8'd4,  8'hFF, 8'd0, 8'd34, 8'hFE},
    {8'd7,  8'h00, 8'd6,  8'h01, 8'd1, 8'd39, 8'h00}
  };

  function automatic logic [63:0] rt(input int c);
    return 64'h0000_0000_0000_0100 | 64'(c);
  endfunction

  function automatic logic [31:0] obs(input int c);
    return {13'd0, hit_o[c], 8'(id_o[c*ID_W +: ID_W]), prio_o[c*8 +: 8], grp_o[c*2 +: 2]};
  endfunction

  function automatic logic [31:0] expv(input logic h, input int id,
                                       input logic [7:0] p, input logic [1:0] g);
    return {13'd0, h, 8'(id), p, g};
  endfunction

  function automatic logic [31:0] idle();
    return expv(1'b0, 0, 8'hFF, 2'd0);
  endfunction

  task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%05h expected=%05h", req, a, e);
    end
  endtask

  task automatic clear_all();
    sec_dis = 1'b1; grp_en = 3'b000;
    pend = '0; en = '0; act = '0; grp = '0; gmod = '0;
    prio = '1; route = '0; part = '0; take = '0;
  endtask

  task automatic set_irq(input int idx, input logic [7:0] p, input logic [63:0] r);
    pend[idx] = 1'b1; en[idx] = 1'b1; grp[idx] = 1'b1;
    prio[idx*8 +: 8] = p; route[idx*64 +: 64] = r;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    clear_all();
    // R10: idle during reset even with an eligible interrupt
    grp_en = 3'b100; set_irq(1, 8'h10, rt(0));
    repeat (3) @(posedge clk); #1;
    for (int c = 0; c < NUM_CORES; c++) chk("R10 reset idle", obs(c), idle());
    clear_all();
    rst_n = 1'b1;
    settle();
    chk("R4 idle after reset", obs(0), idle());

    // Vector table: R3 priority and tie order, R4 0xFF, R8 ID mapping
    for (int v = 0; v < 6; v++) begin
      clear_all(); grp_en = 3'b100;
      set_irq(int'(VEC[v][55:48]), VEC[v][47:40], rt(int'(VEC[v][23:16])));
      set_irq(int'(VEC[v][39:32]), VEC[v][31:24], rt(int'(VEC[v][23:16])));
      settle();
      if (VEC[v][7:0] == 8'hFF)
        chk("R4 R3 vector", obs(int'(VEC[v][23:16])), idle());
      else
        chk("R3 R8 vector", obs(int'(VEC[v][23:16])),
            expv(1'b1, int'(VEC[v][15:8]), VEC[v][7:0], 2'd2));
    end

    // R1: each eligibility term
    clear_all(); grp_en = 3'b100; set_irq(0, 8'h50, rt(0));
    en[0] = 1'b0; settle(); chk("R1 disabled", obs(0), idle());
    en[0] = 1'b1; act[0] = 1'b1; settle(); chk("R1 active", obs(0), idle());
    act[0] = 1'b0; grp_en = 3'b011; settle(); chk("R1 group off", obs(0), idle());
    grp_en = 3'b100; settle(); chk("R1 eligible", obs(0), expv(1'b1, 32, 8'h50, 2'd2));
    pend[0] = 1'b0; settle(); chk("R1 not pending", obs(0), idle());

    // R2: group resolution
    pend[0] = 1'b1; grp[0] = 1'b0; gmod[0] = 1'b1; sec_dis = 1'b0; grp_en = 3'b010;
    settle(); chk("R2 secure group1", obs(0), expv(1'b1, 32, 8'h50, 2'd1));
    grp_en = 3'b100; settle(); chk("R2 secure group1 off", obs(0), idle());
    sec_dis = 1'b1; grp_en = 3'b001;
    settle(); chk("R2 modifier ignored", obs(0), expv(1'b1, 32, 8'h50, 2'd0));

    // R5: affinity field positions
    clear_all(); grp_en = 3'b100; set_irq(3, 8'h33, 64'h0000_0001_0000_0101);
    settle(); chk("R5 aff3 mismatch", obs(1), idle());
    route[3*64 +: 64] = rt(1);
    settle(); chk("R5 direct match", obs(1), expv(1'b1, 35, 8'h33, 2'd2));
    chk("R5 other core idle", obs(0), idle());

    // R6: any-core mode picks first participating, willing core
    clear_all(); grp_en = 3'b100; set_irq(10, 8'h22, 64'h0000_0000_8000_0000);
    part = 4'b1100; take[0*3+2] = 1'b1; take[2*3+2] = 1'b1; take[3*3+2] = 1'b1;
    settle();
    chk("R6 first core", obs(2), expv(1'b1, 42, 8'h22, 2'd2));
    chk("R6 later core idle", obs(3), idle());
    chk("R6 non-participant idle", obs(0), idle());
    take[2*3+2] = 1'b0;
    settle(); chk("R6 unwilling skipped", obs(3), expv(1'b1, 42, 8'h22, 2'd2));

    // R7: unmatched route signals nowhere
    clear_all(); grp_en = 3'b100;
    set_irq(11, 8'h01, 64'h0000_0000_0000_0109); set_irq(12, 8'h40, rt(1));
    settle();
    chk("R7 core0 idle", obs(0), idle());
    chk("R7 core1 unaffected", obs(1), expv(1'b1, 44, 8'h40, 2'd2));
    chk("R7 core2 idle", obs(2), idle());
    chk("R7 core3 idle", obs(3), idle());

    // R9: two-edge latency for appearance and removal
    clear_all(); grp_en = 3'b100; settle();
    set_irq(4, 8'h30, rt(2));
    @(posedge clk); #1; chk("R9 one edge", obs(2), idle());
    @(posedge clk); #1; chk("R9 two edges", obs(2), expv(1'b1, 36, 8'h30, 2'd2));
    en[4] = 1'b0;
    @(posedge clk); #1; chk("R9 removal one edge", obs(2), expv(1'b1, 36, 8'h30, 2'd2));
    @(posedge clk); #1; chk("R9 removal two edges", obs(2), idle());

    done = 1'b1;
    finish_run();
  end
endmodule